// File: doc/BRIEF.md
# Eye-Scan Offset Sweep Sequencer

This block walks a two-dimensional grid of eye-scan sampling offsets and writes one result word for each grid point to memory. Software sets a horizontal range and step, a vertical range and step, a vertical range code, a prescale value, a lane selector and a word-aligned base address. It then writes 1 to the request bit. For each point the block issues a query to the lane-side count responder and waits for the per-lane error counts. It merges the counts of the selected lanes and pushes the result through a memory-write port. It then waits for that write's response before it moves to the next point.

The horizontal offset is the outer loop and the vertical offset is the inner loop. When the selector is 0xFF, every lane takes part and a point reports zero only if every lane reported zero. The request bit clears itself when the sweep ends. Software can also clear it to stop the sweep at the next point boundary. A failed write response sets a sticky error flag and ends the sweep. A separate register holds one eye-scan reset bit per lane.

The point query (`pt_valid`/`pt_ready`) and the memory write (`mw_valid`/`mw_ready`) are valid/ready handshakes. Once valid is raised, it and its payload hold steady until ready is seen high at a clock edge, so the receiver may apply back-pressure for any number of cycles. `cnt_valid` and `mb_valid` are single-cycle responses that the block always accepts. The block keeps at most one query or write outstanding. Configuration inputs must stay stable while the request bit is set.

Top module: `eye_sweep_seq`

## Requirements
- R1: After reset, `req_bit`, `err_flag`, `pt_valid`, `mw_valid` and every bit of `lane_rst` are 0.
- R2: A write of 1 to the request bit while the block is idle starts a sweep and clears `err_flag`; `req_bit` reads 1 from the next cycle. A write of 1 while a sweep is running has no effect.
- R3: Grid order: the horizontal offset runs from `h_min` and the vertical offset from `v_min`; each advances by its step while the new value does not exceed its maximum. The vertical offset is the inner loop. A step of 0 gives a single value on that axis. If `h_min > h_max` or `v_min > v_max`, the sweep has no points and `req_bit` stays 0.
- R4: Each point produces exactly one write. The k-th write (k from 0) goes to `base_addr + 4*k`, and no point query is outstanding while a write is pending.
- R5: With `lane_sel` = 0xFF, `pt_lanes` is all ones and the written word is the bitwise OR of all lane counts, so it is zero only if every lane count is zero. Otherwise only lane `lane_sel` is selected (a one-hot `pt_lanes`). A selector at or above the lane count selects no lane and yields 0. The count sits in bits [CW-1:0] of the word, and the upper bits are 0.
- R6: After the write response of the last point, `req_bit` returns to 0 and no further query is issued.
- R7: A write of 0 to the request bit during a sweep clears `req_bit` at once. No new point query is issued after the response for the point in flight.
- R8: A write response with `mb_err` set raises `err_flag`, clears `req_bit` and ends the sweep. `err_flag` stays set until the next accepted start.
- R9: Once `pt_valid` or `mw_valid` is raised, it and its payload stay stable until the matching ready is seen.
- R10: A pulse on `lrst_wr` loads `lrst_wdata` into `lane_rst`, whether or not a sweep is running.
- R11: Each point query carries the current `prescale` and `v_range` values on `pt_prescale` and `pt_vrange`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request bit write strobe |
| req_wdata | input | 1 | Value written to the request bit |
| req_bit | output | 1 | Request bit; 1 while a sweep runs |
| lane_sel | input | 8 | Lane selector; 0xFF selects all lanes |
| prescale | input | 5 | Prescale value passed with each query |
| v_range | input | 2 | Vertical range code passed with each query |
| v_min | input | VW | Vertical start offset |
| v_max | input | VW | Vertical upper limit |
| v_step | input | VW | Vertical increment |
| h_min | input | HW | Horizontal start offset |
| h_max | input | HW | Horizontal upper limit |
| h_step | input | HW | Horizontal increment |
| base_addr | input | AW | Address of the first result word |
| lrst_wr | input | 1 | Lane reset register write strobe |
| lrst_wdata | input | LANES | Lane reset register write value |
| lane_rst | output | LANES | Per-lane eye-scan reset bits |
| err_flag | output | 1 | Sticky write-error flag |
| pt_valid | output | 1 | Point query valid |
| pt_ready | input | 1 | Point query ready |
| pt_hoff | output | HW | Horizontal offset of the query |
| pt_voff | output | VW | Vertical offset of the query |
| pt_vrange | output | 2 | Vertical range code of the query |
| pt_prescale | output | 5 | Prescale of the query |
| pt_lanes | output | LANES | Lanes addressed by the query |
| cnt_valid | input | 1 | Per-lane counts valid (one cycle) |
| cnt_data | input | LANES*CW | Per-lane error counts, lane i in bits [i*CW +: CW] |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write ready |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mb_valid | input | 1 | Write response valid (one cycle) |
| mb_err | input | 1 | Write response error |

## Verification
The sweep is tried with a 3-by-4 broadcast grid and with a single selected lane. Their counts are built so that only some lanes are non-zero at each point, which separates an OR of the selected lanes from any one lane's count. A grid with a zero vertical step, and grids whose minimum is above the maximum, separate correct loop termination from off-by-one or endless stepping. A selector beyond the lane count checks that no lane leaks into the result. Mid-sweep stop, an ignored re-start, and an error response on the second write check how the sweep ends and which flags remain. Memory back-pressure of two cycles on every write checks that the payload holds steady.

// File: rtl/eyesweep_pkg.sv
package eyesweep_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAITC,
    S_WRITE,
    S_RESP
  } sweep_st_t;
  localparam logic [7:0] SEL_ALL = 8'hFF;
endpackage

// File: rtl/eye_grid_cnt.sv
module eye_grid_cnt #(
  parameter int HW = 12,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [HW-1:0] h_min,
  input  logic [HW-1:0] h_max,
  input  logic [HW-1:0] h_step,
  input  logic [VW-1:0] v_min,
  input  logic [VW-1:0] v_max,
  input  logic [VW-1:0] v_step,
  output logic [HW-1:0] h_cur,
  output logic [VW-1:0] v_cur,
  output logic          last,
  output logic          empty
);
  logic [HW:0] h_nxt;
  logic [VW:0] v_nxt;
  logic        h_more, v_more;

  assign h_nxt  = {1'b0, h_cur} + {1'b0, h_step};
  assign v_nxt  = {1'b0, v_cur} + {1'b0, v_step};
  assign h_more = (h_step != '0) && (h_nxt <= {1'b0, h_max});
  assign v_more = (v_step != '0) && (v_nxt <= {1'b0, v_max});
  assign last   = !h_more && !v_more;
  assign empty  = (h_min > h_max) || (v_min > v_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cur <= '0;
      v_cur <= '0;
    end else if (load) begin
      h_cur <= h_min;
      v_cur <= v_min;
    end else if (adv) begin
      if (v_more) begin
        v_cur <= v_nxt[VW-1:0];
      end else begin
        v_cur <= v_min;
        h_cur <= h_nxt[HW-1:0];
      end
    end
  end
endmodule

// File: rtl/eye_lane_merge.sv
module eye_lane_merge #(
  parameter int LANES = 4,
  parameter int CW    = 16
) (
  input  logic [7:0]          lane_sel,
  input  logic [LANES*CW-1:0] cnt_data,
  output logic [LANES-1:0]    mask,
  output logic [CW-1:0]       merged
);
  logic             all_sel;
  logic [CW-1:0]    gated [LANES];

  assign all_sel = (lane_sel == eyesweep_pkg::SEL_ALL);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i]  = all_sel || (lane_sel == 8'(i));
    assign gated[i] = mask[i] ? cnt_data[i*CW +: CW] : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < LANES; i++) merged = merged | gated[i];
  end
endmodule

// File: rtl/eye_sweep_seq.sv
module eye_sweep_seq
  import eyesweep_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 16,
  parameter int HW    = 12,
  parameter int VW    = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic                req_wdata,
  output logic                req_bit,
  input  logic [7:0]          lane_sel,
  input  logic [4:0]          prescale,
  input  logic [1:0]          v_range,
  input  logic [VW-1:0]       v_min,
  input  logic [VW-1:0]       v_max,
  input  logic [VW-1:0]       v_step,
  input  logic [HW-1:0]       h_min,
  input  logic [HW-1:0]       h_max,
  input  logic [HW-1:0]       h_step,
  input  logic [AW-1:0]       base_addr,
  input  logic                lrst_wr,
  input  logic [LANES-1:0]    lrst_wdata,
  output logic [LANES-1:0]    lane_rst,
  output logic                err_flag,
  output logic                pt_valid,
  input  logic                pt_ready,
  output logic [HW-1:0]       pt_hoff,
  output logic [VW-1:0]       pt_voff,
  output logic [1:0]          pt_vrange,
  output logic [4:0]          pt_prescale,
  output logic [LANES-1:0]    pt_lanes,
  input  logic                cnt_valid,
  input  logic [LANES*CW-1:0] cnt_data,
  output logic                mw_valid,
  input  logic                mw_ready,
  output logic [AW-1:0]       mw_addr,
  output logic [DW-1:0]       mw_data,
  input  logic                mb_valid,
  input  logic                mb_err
);
  localparam int WORD_BYTES = DW / 8;

  sweep_st_t      st;
  logic           req_q, err_q;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  res_q, merged;
  logic           sw_stop, start, grid_last, grid_empty, adv, resp_ok;

  assign sw_stop = req_wr && !req_wdata;
  assign start   = req_wr && req_wdata && (st == S_IDLE);
  assign resp_ok = (st == S_RESP) && mb_valid && !mb_err;
  assign adv     = resp_ok && req_q && !sw_stop && !grid_last;

  eye_grid_cnt #(.HW(HW), .VW(VW)) u_grid (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .adv   (adv),
    .h_min (h_min),
    .h_max (h_max),
    .h_step(h_step),
    .v_min (v_min),
    .v_max (v_max),
    .v_step(v_step),
    .h_cur (pt_hoff),
    .v_cur (pt_voff),
    .last  (grid_last),
    .empty (grid_empty)
  );

  eye_lane_merge #(.LANES(LANES), .CW(CW)) u_merge (
    .lane_sel(lane_sel),
    .cnt_data(cnt_data),
    .mask    (pt_lanes),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      res_q  <= '0;
    end else begin
      if (sw_stop) req_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          err_q <= 1'b0;
          if (!grid_empty) begin
            req_q  <= 1'b1;
            addr_q <= base_addr;
            st     <= S_ISSUE;
          end
        end
        S_ISSUE: if (pt_ready) st <= S_WAITC;
        S_WAITC: if (cnt_valid) begin
          res_q <= merged;
          st    <= S_WRITE;
        end
        S_WRITE: if (mw_ready) st <= S_RESP;
        S_RESP: if (mb_valid) begin
          if (mb_err) begin
            err_q <= 1'b1;
            req_q <= 1'b0;
            st    <= S_IDLE;
          end else if (!req_q || sw_stop) begin
            st <= S_IDLE;
          end else if (grid_last) begin
            req_q <= 1'b0;
            st    <= S_IDLE;
          end else begin
            addr_q <= addr_q + AW'(WORD_BYTES);
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       lane_rst <= '0;
    else if (lrst_wr) lane_rst <= lrst_wdata;
  end

  assign req_bit     = req_q;
  assign err_flag    = err_q;
  assign pt_valid    = (st == S_ISSUE);
  assign pt_vrange   = v_range;
  assign pt_prescale = prescale;
  assign mw_valid    = (st == S_WRITE);
  assign mw_addr     = addr_q;
  assign mw_data     = {{(DW-CW){1'b0}}, res_q};
endmodule

// File: rtl/eye_sweep_chk.sv
module eye_sweep_chk #(
  parameter int LANES = 4,
  parameter int HW    = 12,
  parameter int VW    = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_bit,
  input logic             err_flag,
  input logic [7:0]       lane_sel,
  input logic [HW-1:0]    h_min,
  input logic [HW-1:0]    h_max,
  input logic [VW-1:0]    v_min,
  input logic [VW-1:0]    v_max,
  input logic             pt_valid,
  input logic             pt_ready,
  input logic [HW-1:0]    pt_hoff,
  input logic [VW-1:0]    pt_voff,
  input logic [LANES-1:0] pt_lanes,
  input logic             mw_valid,
  input logic             mw_ready,
  input logic [AW-1:0]    mw_addr,
  input logic [DW-1:0]    mw_data,
  input logic             mb_valid,
  input logic             mb_err
);
  AST_PT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && !pt_ready |=> pt_valid && $stable(pt_hoff) && $stable(pt_voff)); // R9
  AST_MW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(pt_valid && mw_valid)); // R4
  AST_GRID_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> pt_hoff >= h_min && pt_hoff <= h_max && pt_voff >= v_min && pt_voff <= v_max); // R3
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && lane_sel != 8'hFF |-> $countones(pt_lanes) <= 1); // R5
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid && mb_err && req_bit && !pt_valid && !mw_valid |=> !req_bit && err_flag); // R8
endmodule

bind eye_sweep_seq eye_sweep_chk #(
  .LANES(LANES), .HW(HW), .VW(VW), .AW(AW), .DW(DW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_bit (req_bit),
  .err_flag(err_flag),
  .lane_sel(lane_sel),
  .h_min   (h_min),
  .h_max   (h_max),
  .v_min   (v_min),
  .v_max   (v_max),
  .pt_valid(pt_valid),
  .pt_ready(pt_ready),
  .pt_hoff (pt_hoff),
  .pt_voff (pt_voff),
  .pt_lanes(pt_lanes),
  .mw_valid(mw_valid),
  .mw_ready(mw_ready),
  .mw_addr (mw_addr),
  .mw_data (mw_data),
  .mb_valid(mb_valid),
  .mb_err  (mb_err)
);

// File: tb/sim_eye_sweep_seq.sv
`timescale 1ns/1ps
module sim_eye_sweep_seq;
  localparam int LANES = 4, CW = 16, HW = 12, VW = 8, AW = 32, DW = 32;
  localparam int MAXW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_wr = 0, req_wdata = 0, req_bit;
  logic [7:0] lane_sel = 8'hFF;
  logic [4:0] prescale = 5'd9;
  logic [1:0] v_range = 2'd2;
  logic [VW-1:0] v_min = 0, v_max = 0, v_step = 0;
  logic [HW-1:0] h_min = 0, h_max = 0, h_step = 0;
  logic [AW-1:0] base_addr = 0;
  logic lrst_wr = 0;
  logic [LANES-1:0] lrst_wdata = 0, lane_rst;
  logic err_flag, pt_valid, pt_ready = 0;
  logic [HW-1:0] pt_hoff;
  logic [VW-1:0] pt_voff;
  logic [1:0] pt_vrange;
  logic [4:0] pt_prescale;
  logic [LANES-1:0] pt_lanes;
  logic cnt_valid = 0;
  logic [LANES*CW-1:0] cnt_data = '0;
  logic mw_valid, mw_ready = 0;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;
  logic mb_valid = 0, mb_err = 0;

  int n_chk = 0, n_bad = 0;
  int wr_n = 0, pt_n = 0, err_at = -1, r9_bad = 0, r11_bad = 0;
  logic [AW-1:0] wr_addr [MAXW];
  logic [DW-1:0] wr_data [MAXW];
  int pt_h [MAXW];
  int pt_v [MAXW];
  logic [LANES-1:0] pt_m [MAXW];

  always #2.5 clk = ~clk;

  eye_sweep_seq #(.LANES(LANES), .CW(CW), .HW(HW), .VW(VW), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata), .req_bit(req_bit),
    .lane_sel(lane_sel), .prescale(prescale), .v_range(v_range),
    .v_min(v_min), .v_max(v_max), .v_step(v_step),
    .h_min(h_min), .h_max(h_max), .h_step(h_step), .base_addr(base_addr),
    .lrst_wr(lrst_wr), .lrst_wdata(lrst_wdata), .lane_rst(lane_rst), .err_flag(err_flag),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_hoff(pt_hoff), .pt_voff(pt_voff),
    .pt_vrange(pt_vrange), .pt_prescale(pt_prescale), .pt_lanes(pt_lanes),
    .cnt_valid(cnt_valid), .cnt_data(cnt_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mb_valid(mb_valid), .mb_err(mb_err));

  function automatic logic [CW-1:0] lane_cnt(int l, int h, int v);
    if (((h + 3*v + l) % 5) == 0) return CW'(h*7 + v + l*16 + 1);
    return '0;
  endfunction

  function automatic logic [DW-1:0] exp_word(int sel, int h, int v);
    logic [CW-1:0] acc = '0;
    if (sel == 255) begin
      for (int l = 0; l < LANES; l++) acc = acc | lane_cnt(l, h, v);
    end else if (sel < LANES) begin
      acc = lane_cnt(sel, h, v);
    end
    return DW'(acc);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Lane-side responder: accepts a query, answers with per-lane counts
  initial begin
    forever begin
      @(negedge clk);
      if (pt_valid) begin
        if (pt_n < MAXW) begin
          pt_h[pt_n] = int'(pt_hoff);
          pt_v[pt_n] = int'(pt_voff);
          pt_m[pt_n] = pt_lanes;
        end
        if (pt_prescale !== prescale || pt_vrange !== v_range) r11_bad++;
        pt_n++;
        pt_ready = 1;
        @(negedge clk);
        pt_ready = 0;
        for (int l = 0; l < LANES; l++)
          cnt_data[l*CW +: CW] = lane_cnt(l, pt_h[(pt_n-1) % MAXW], pt_v[(pt_n-1) % MAXW]);
        @(negedge clk);
        cnt_valid = 1;
        @(negedge clk);
        cnt_valid = 0;
      end
    end
  end

  // Memory model: two cycles of back-pressure, then a response
  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    forever begin
      @(negedge clk);
      if (mw_valid) begin
        a = mw_addr;
        d = mw_data;
        repeat (2) begin
          @(negedge clk);
          if (!mw_valid || mw_addr !== a || mw_data !== d) r9_bad++;
        end
        if (wr_n < MAXW) begin
          wr_addr[wr_n] = mw_addr;
          wr_data[wr_n] = mw_data;
        end
        wr_n++;
        mw_ready = 1;
        @(negedge clk);
        mw_ready = 0;
        mb_valid = 1;
        mb_err = ((wr_n - 1) == err_at);
        @(negedge clk);
        mb_valid = 0;
        mb_err = 0;
      end
    end
  end

  task automatic pulse_req(bit val);
    @(negedge clk);
    req_wr = 1; req_wdata = val;
    @(negedge clk);
    req_wr = 0; req_wdata = 0;
  endtask

  task automatic wait_idle(string tag);
    int t = 0;
    while (req_bit && t < 20000) begin @(negedge clk); t++; end
    chk(!req_bit, tag, req_bit, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic config_grid(int sel, int h0, int h1, int hs, int v0, int v1, int vs, int base);
    lane_sel = 8'(sel);
    h_min = HW'(h0); h_max = HW'(h1); h_step = HW'(hs);
    v_min = VW'(v0); v_max = VW'(v1); v_step = VW'(vs);
    base_addr = AW'(base);
    wr_n = 0; pt_n = 0;
  endtask

  // Full sweep checked against a bench-side grid walk
  task automatic t_sweep(string tag, int sel, int h0, int h1, int hs, int v0, int v1, int vs, int base);
    int k = 0;
    int h, v;
    config_grid(sel, h0, h1, hs, v0, v1, vs, base);
    pulse_req(1);
    chk(req_bit === 1'b1, {tag, " R2 req set"}, req_bit, 1);
    wait_idle({tag, " R6 req cleared"});
    h = h0;
    while (h <= h1) begin
      v = v0;
      while (v <= v1) begin
        if (k < wr_n && k < MAXW) begin
          chk(pt_h[k] == h && pt_v[k] == v, {tag, " R3 point order"}, (pt_h[k] << 8) | pt_v[k], (h << 8) | v);
          chk(wr_addr[k] == AW'(base + 4*k), {tag, " R4 address"}, wr_addr[k], base + 4*k);
          chk(wr_data[k] == exp_word(sel, h, v), {tag, " R5 merged count"}, wr_data[k], exp_word(sel, h, v));
          chk(pt_prescale === prescale, {tag, " R11 prescale"}, pt_prescale, prescale);
        end
        k++;
        if (vs == 0) break;
        v += vs;
      end
      if (hs == 0) break;
      h += hs;
    end
    chk(wr_n == k, {tag, " R3 point count"}, wr_n, k);
    chk(pt_n == k, {tag, " R4 one query per write"}, pt_n, k);
    chk(r11_bad == 0, {tag, " R11 query fields"}, r11_bad, 0);
    chk(r9_bad == 0, {tag, " R9 write payload stable"}, r9_bad, 0);
  endtask

  task automatic t_reset;
    chk(req_bit === 0 && err_flag === 0, "R1 req/err after reset", {req_bit, err_flag}, 0);
    chk(pt_valid === 0 && mw_valid === 0, "R1 valids after reset", {pt_valid, mw_valid}, 0);
    chk(lane_rst === '0, "R1 lane_rst after reset", lane_rst, 0);
  endtask

  task automatic t_empty;
    config_grid(255, 5, 4, 1, 0, 3, 1, 'h100);
    pulse_req(1);
    chk(req_bit === 0, "R3 empty horizontal range", req_bit, 0);
    config_grid(255, 0, 3, 1, 9, 2, 1, 'h100);
    pulse_req(1);
    repeat (20) @(negedge clk);
    chk(req_bit === 0, "R3 empty vertical range", req_bit, 0);
    chk(wr_n == 0 && pt_n == 0, "R3 no points on empty grid", wr_n + pt_n, 0);
  endtask

  task automatic t_stop;
    int t = 0;
    config_grid(255, 0, 20, 1, 0, 10, 1, 'h2000);
    pulse_req(1);
    while (wr_n < 1 && t < 2000) begin @(negedge clk); t++; end
    pulse_req(1);  // ignored: sweep already running
    chk(req_bit === 1'b1, "R2 start while running ignored", req_bit, 1);
    while (wr_n < 3 && t < 4000) begin @(negedge clk); t++; end
    pulse_req(0);
    chk(req_bit === 0, "R7 req cleared by software", req_bit, 0);
    repeat (60) @(negedge clk);
    chk(wr_n == 3, "R7 writes after stop", wr_n, 3);
    chk(pt_n == 3, "R7 queries after stop", pt_n, 3);
    chk(wr_addr[2] == AW'('h2008), "R2 base kept despite ignored start", wr_addr[2], 'h2008);
    chk(pt_valid === 0 && mw_valid === 0, "R7 quiet after stop", {pt_valid, mw_valid}, 0);
  endtask

  task automatic t_err;
    config_grid(255, 0, 4, 2, 0, 6, 3, 'h300);
    err_at = 1;
    pulse_req(1);
    wait_idle("R8 req cleared on error");
    chk(err_flag === 1'b1, "R8 error flag set", err_flag, 1);
    chk(wr_n == 2 && pt_n == 2, "R8 sweep ended at failing write", (wr_n << 8) | pt_n, (2 << 8) | 2);
    repeat (10) @(negedge clk);
    chk(err_flag === 1'b1, "R8 error flag sticky", err_flag, 1);
    err_at = -1;
    config_grid(255, 1, 1, 0, 1, 1, 0, 'h400);
    pulse_req(1);
    chk(err_flag === 1'b0, "R8 error flag cleared by start", err_flag, 0);
    wait_idle("R6 single point sweep done");
    chk(wr_n == 1, "R3 single point", wr_n, 1);
  endtask

  task automatic t_lanes;
    config_grid(2, 0, 3, 1, 0, 3, 1, 'h500);
    pulse_req(1);
    @(negedge clk);
    @(negedge clk);
    lrst_wr = 1; lrst_wdata = 4'b1010;
    @(negedge clk);
    lrst_wr = 0;
    chk(lane_rst === 4'b1010, "R10 lane reset written during sweep", lane_rst, 4'b1010);
    wait_idle("R6 lane sweep done");
    chk(pt_m[0] === 4'b0100, "R5 one-hot lane mask", pt_m[0], 4'b0100);
    lrst_wr = 1; lrst_wdata = 4'b0101;
    @(negedge clk);
    lrst_wr = 0;
    chk(lane_rst === 4'b0101, "R10 lane reset rewrite", lane_rst, 4'b0101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sweep("bcast 3x4", 255, 0, 4, 2, 1, 10, 3, 'h1000);
    t_sweep("lane1", 1, 3, 5, 1, 0, 4, 2, 'h1800);
    t_sweep("vstep0", 255, 2, 8, 3, 7, 200, 0, 'h1c00);
    t_sweep("sel out of range", 9, 0, 2, 1, 0, 2, 1, 'h1e00);
    chk(pt_m[0] === '0, "R5 no lane for out-of-range selector", pt_m[0], 0);
    t_sweep("bcast mask", 255, 10, 10, 1, 4, 5, 1, 'h1f00);
    chk(pt_m[0] === '1, "R5 broadcast mask all ones", pt_m[0], 4'hF);
    t_empty();
    t_stop();
    t_err();
    t_lanes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule